// File: doc/BRIEF.md
# Exact Leading Zero Anticipator

This block predicts how many leading zeros the N-bit result of an integer add or subtract will have, working from the operands alone, so that a normalising shift amount is ready at roughly the same time as the adder's sum. It does not form the sum. Subtraction is treated as A plus the bitwise inverse of B plus a carry-in of one. Any carry out of the top bit is dropped.

Each bit position is classed as propagate, generate or kill. A binary tree of blocks then merges these classes. Every block keeps two answers, one assuming a carry enters it from below and one assuming none. Each answer is a flag saying the block's result bits are all zero, together with the block's leading zero count. When two halves are merged, the carry the lower half hands to the upper half selects which of the upper half's answers applies. With a carry coming in, the lower half passes a carry upward unless it kills. With no carry coming in, it passes a carry upward only if it generates.

At the root, the real carry-in (the subtract flag) picks the final answer. The count is exact; no one-bit correction step is needed. The block is purely combinational.

Top module: `exact_lza`

## Requirements
- R1: With `sub_en` = 0, `lz_count` equals the number of leading zeros of (a_op + b_op) mod 2^N, counted from bit N-1 downward.
- R2: With `sub_en` = 1, `lz_count` equals the number of leading zeros of (a_op - b_op) mod 2^N, which is a_op + ~b_op + 1 modulo 2^N.
- R3: A result that is entirely zero reports `lz_count` = N. This covers equal operands under subtraction, and a sum that wraps exactly to 2^N under addition.
- R4: The carry out of bit N-1 has no effect on the count. Only the low N result bits are counted.
- R5: The count is exact, including results whose leading zeros are produced by a long carry chain (for example 0111...1 + 0...01). `lz_count` never exceeds N.
- R6: Widths that are not a power of two are supported. At N = 12, 101100111100 minus 100111101111 gives 000101001101, and the count is 3.
- R7: `lz_count` is a pure function of the current inputs. It settles without any clock and is ceil(log2(N+1)) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | N | First operand, unsigned |
| b_op | input | N | Second operand, unsigned |
| sub_en | input | 1 | 1 selects a_op - b_op, 0 selects a_op + b_op |
| lz_count | output | ceil(log2(N+1)) | Leading zero count of the N-bit result; N when the result is zero |

## Verification
A block inside the tree that picks the wrong carry assumption shows up at once as a wrong count, on the very vector that exposes it, because nothing is stored. The errors usually take one of three forms. The count can be off by one when the lower half's carry is mishandled. It can be short by a whole lower-half width when an all-zero flag is wrong. It can be wrong only under subtraction when the root selection is swapped. For this reason, carry chains that end exactly at a block boundary, equal operands, and exact wrap-around sums are applied alongside random operands in both modes.

// File: rtl/lza_pkg.sv
// Shared types and helpers for the leading zero anticipator.
// Assumes widths of at least one bit.
package lza_pkg;

    // Per-position carry behaviour of an operand bit pair.
    typedef struct packed {
        logic prop;
        logic gen;
        logic kill;
    } pgk_t;

    // Bits needed to hold a count from 0 up to and including w.
    function automatic int cnt_w(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/lza_pgk_cell.sv
// Classifies each operand bit pair as propagate, generate or kill.
// Assumes the second operand has already been inverted for subtraction.
module lza_pgk_cell #(
    parameter int N = 16
) (
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    output logic [N-1:0] prop_o,
    output logic [N-1:0] gen_o,
    output logic [N-1:0] kill_o
);
    import lza_pkg::*;

    pgk_t cls [N];

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Classify one bit position from its two operand bits.
        always_comb begin
            cls[i].prop = x_in[i] ^ y_in[i];
            cls[i].gen  = x_in[i] & y_in[i];
            cls[i].kill = ~(x_in[i] | y_in[i]);
        end

        assign prop_o[i] = cls[i].prop;
        assign gen_o[i]  = cls[i].gen;
        assign kill_o[i] = cls[i].kill;

        // Exactly one class per position.
        always_comb begin
            AST_BIT_CLASS_ONEHOT: assert ($onehot({cls[i].prop, cls[i].gen, cls[i].kill})); // R5
        end
    end

endmodule

// File: rtl/lza_node.sv
// One block of the anticipation tree, covering W bit positions.
// It builds itself recursively from an upper half of ceil(W/2) bits and a
// lower half of floor(W/2) bits. For both carry-in assumptions it reports
// the block's carry class, an all-zero flag and a leading zero count.
// Assumes W >= 1 and exactly one class set per input position.
module lza_node #(
    parameter int W = 16
) (
    input  logic [W-1:0]                 prop_i,
    input  logic [W-1:0]                 gen_i,
    input  logic [W-1:0]                 kill_i,
    output logic                         blk_prop,
    output logic                         blk_gen,
    output logic                         blk_kill,
    output logic                         zero_ci,
    output logic                         zero_nc,
    output logic [lza_pkg::cnt_w(W)-1:0] cnt_ci,
    output logic [lza_pkg::cnt_w(W)-1:0] cnt_nc
);
    import lza_pkg::*;

    localparam int CW = cnt_w(W);

    if (W == 1) begin : g_leaf
        // A single bit is zero under carry exactly when it propagates.
        always_comb begin
            blk_prop = prop_i[0];
            blk_gen  = gen_i[0];
            blk_kill = kill_i[0];
            zero_ci  = prop_i[0];
            zero_nc  = ~prop_i[0];
            cnt_ci   = CW'(prop_i[0]);
            cnt_nc   = CW'(~prop_i[0]);
        end
    end else begin : g_join
        localparam int WR  = W / 2;
        localparam int WL  = W - WR;
        localparam int CWL = cnt_w(WL);
        localparam int CWR = cnt_w(WR);

        logic           up_p, up_g, up_k, up_zc, up_zn;
        logic           lo_p, lo_g, lo_k, lo_zc, lo_zn;
        logic [CWL-1:0] up_cc, up_cn;
        logic [CWR-1:0] lo_cc, lo_cn;
        logic           carry_up_ci, carry_up_nc;
        logic           up_zero_ci, up_zero_nc;
        logic [CW-1:0]  up_cnt_ci, up_cnt_nc;

        lza_node #(.W(WL)) u_upper (
            .prop_i   (prop_i[W-1:WR]),
            .gen_i    (gen_i[W-1:WR]),
            .kill_i   (kill_i[W-1:WR]),
            .blk_prop (up_p),
            .blk_gen  (up_g),
            .blk_kill (up_k),
            .zero_ci  (up_zc),
            .zero_nc  (up_zn),
            .cnt_ci   (up_cc),
            .cnt_nc   (up_cn)
        );

        lza_node #(.W(WR)) u_lower (
            .prop_i   (prop_i[WR-1:0]),
            .gen_i    (gen_i[WR-1:0]),
            .kill_i   (kill_i[WR-1:0]),
            .blk_prop (lo_p),
            .blk_gen  (lo_g),
            .blk_kill (lo_k),
            .zero_ci  (lo_zc),
            .zero_nc  (lo_zn),
            .cnt_ci   (lo_cc),
            .cnt_nc   (lo_cn)
        );

        // Merge carry classes: the upper half decides unless it propagates.
        always_comb begin
            blk_prop = up_p & lo_p;
            blk_gen  = up_g | (up_p & lo_g);
            blk_kill = up_k | (up_p & lo_k);
        end

        // Carry the lower half hands upward under each assumption.
        always_comb begin
            carry_up_ci = ~lo_k;
            carry_up_nc = lo_g;
        end

        // Pick the upper half's answer that matches the carry it receives.
        always_comb begin
            up_zero_ci = carry_up_ci ? up_zc : up_zn;
            up_zero_nc = carry_up_nc ? up_zc : up_zn;
            up_cnt_ci  = carry_up_ci ? CW'(up_cc) : CW'(up_cn);
            up_cnt_nc  = carry_up_nc ? CW'(up_cc) : CW'(up_cn);
        end

        // Combine flags and counts; extend into the lower half when the upper is all zero.
        always_comb begin
            zero_ci = lo_zc & up_zero_ci;
            zero_nc = lo_zn & up_zero_nc;
            cnt_ci  = up_zero_ci ? (CW'(WL) + CW'(lo_cc)) : up_cnt_ci;
            cnt_nc  = up_zero_nc ? (CW'(WL) + CW'(lo_cn)) : up_cnt_nc;
        end

        // Check that the merged results are consistent with each other.
        always_comb begin
            AST_ZERO_CI_IS_ALL_PROP: assert (zero_ci == blk_prop);                  // R5
            AST_CLASS_ONEHOT:        assert ($onehot({blk_prop, blk_gen, blk_kill})); // R5
            AST_CNT_CI_BOUNDED:      assert (cnt_ci <= CW'(W));                     // R5
            AST_CNT_NC_BOUNDED:      assert (cnt_nc <= CW'(W));                     // R5
            AST_FULL_CNT_CI:         assert (zero_ci == (cnt_ci == CW'(W)));        // R3
            AST_FULL_CNT_NC:         assert (zero_nc == (cnt_nc == CW'(W)));        // R3
        end
    end

endmodule

// File: rtl/exact_lza.sv
// Exact leading zero anticipator for an N-bit add or subtract.
// It inverts B for subtraction, classifies the bit pairs, and runs the block
// tree. The subtract flag, acting as the real carry-in, then selects the
// root answer. Purely combinational; the carry out of the top bit is ignored.
module exact_lza #(
    parameter int N = 16
) (
    input  logic [N-1:0]                 a_op,
    input  logic [N-1:0]                 b_op,
    input  logic                         sub_en,
    output logic [lza_pkg::cnt_w(N)-1:0] lz_count
);
    import lza_pkg::*;

    localparam int CW = cnt_w(N);

    logic [N-1:0]  b_eff;
    logic [N-1:0]  prop, gen, kill;
    logic          root_p, root_g, root_k, root_zc, root_zn;
    logic [CW-1:0] root_cc, root_cn;

    // Form the second operand of the carry-save view.
    always_comb begin
        b_eff = sub_en ? ~b_op : b_op;
    end

    lza_pgk_cell #(.N(N)) u_cells (
        .x_in   (a_op),
        .y_in   (b_eff),
        .prop_o (prop),
        .gen_o  (gen),
        .kill_o (kill)
    );

    lza_node #(.W(N)) u_root (
        .prop_i   (prop),
        .gen_i    (gen),
        .kill_i   (kill),
        .blk_prop (root_p),
        .blk_gen  (root_g),
        .blk_kill (root_k),
        .zero_ci  (root_zc),
        .zero_nc  (root_zn),
        .cnt_ci   (root_cc),
        .cnt_nc   (root_cn)
    );

    // Choose the root answer for the actual carry-in.
    always_comb begin
        lz_count = sub_en ? root_cc : root_cn;
    end

    // Check the final count against the operands directly.
    always_comb begin
        AST_COUNT_NOT_ABOVE_N: assert (lz_count <= CW'(N));                        // R5
        AST_EQUAL_SUB_FULL:    assert (!(sub_en && a_op == b_op) || lz_count == CW'(N)); // R3
        AST_ROOT_CLASS_ONEHOT: assert ($onehot({root_p, root_g, root_k}));        // R5
        AST_ROOT_FLAG_COUNT:   assert ((sub_en ? root_zc : root_zn) == (lz_count == CW'(N))); // R3
    end

endmodule

// File: tb/sim_exact_lza.sv
module sim_exact_lza;

    localparam int N  = 16;
    localparam int CW = $clog2(N + 1);
    localparam int M  = 12;
    localparam int CM = $clog2(M + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a, b;
    logic          sub;
    logic [CW-1:0] cnt;
    logic [M-1:0]  a12, b12;
    logic          sub12;
    logic [CM-1:0] cnt12;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;

    exact_lza #(.N(N)) u0 (.a_op(a), .b_op(b), .sub_en(sub), .lz_count(cnt));
    exact_lza #(.N(M)) u1 (.a_op(a12), .b_op(b12), .sub_en(sub12), .lz_count(cnt12));

    // Software count of leading zeros of the low n bits of v.
    function automatic int ref_lz(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            if (v[i]) return n - 1 - i;
        end
        return n;
    endfunction

    function automatic int ref_op(input logic [N-1:0] x, input logic [N-1:0] y, input logic s);
        logic [N-1:0] r;
        r = s ? (x - y) : (x + y);
        return ref_lz({16'h0, r}, N);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h sub=%0d actual=%0d expected=%0d", req, a, b, sub, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic s, input string req);
        @(negedge clk);
        a = x; b = y; sub = s;
        #1;
        chk(req, int'(cnt), ref_op(x, y, s));
    endtask

    // Reset state: zero operands with addition give a full count.
    task automatic t_reset;
        @(negedge clk);
        a = '0; b = '0; sub = 1'b0;
        #1;
        chk("R3 reset/zero", int'(cnt), N);
        rst_n = 1'b1;
    endtask

    // Directed additions, including carry chains into each boundary.
    task automatic t_add_directed;
        apply(16'h7FFF, 16'h0001, 1'b0, "R5 chain to msb");
        apply(16'h00FF, 16'h0001, 1'b0, "R5 chain to block edge");
        apply(16'h0000, 16'h0001, 1'b0, "R1 single low one");
        apply(16'h1234, 16'h0100, 1'b0, "R1 plain add");
        apply(16'h0007, 16'h0009, 1'b0, "R5 chain at nibble");
        for (int i = 0; i < N; i++) begin
            apply(16'(1 << i) - 16'd1, 16'h0001, 1'b0, "R5 sweep carry chain");
        end
    endtask

    // Directed subtractions with small and borrow-heavy differences.
    task automatic t_sub_directed;
        apply(16'h8000, 16'h7FFF, 1'b1, "R2 diff one");
        apply(16'h0100, 16'h00FF, 1'b1, "R2 borrow chain");
        apply(16'h0000, 16'h0001, 1'b1, "R2 negative wrap");
        apply(16'hB33C, 16'h9EEF, 1'b1, "R2 mixed");
        for (int i = 0; i < N; i++) begin
            apply(16'(1 << i), 16'(1 << i) - 16'd1, 1'b1, "R2 sweep borrow");
        end
    endtask

    // All-zero results: equal operands and exact wrap of the sum.
    task automatic t_zero_results;
        apply(16'hA5A5, 16'hA5A5, 1'b1, "R3 equal operands");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R3 equal ones");
        apply(16'h0000, 16'h0000, 1'b1, "R3 equal zeros");
        apply(16'h8000, 16'h8000, 1'b0, "R4 wrap to zero");
        apply(16'hFFFF, 16'h0001, 1'b0, "R4 wrap to zero");
        apply(16'hFFFF, 16'h0002, 1'b0, "R4 carry out ignored");
        @(negedge clk);
        a = 16'h1357; b = 16'h1357; sub = 1'b1;
        #1;
        chk("R3 explicit N", int'(cnt), N);
    endtask

    // Random operands in both modes, and equal operands at random.
    task automatic t_random;
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] x, y;
            x = 16'($urandom);
            y = 16'($urandom);
            if (i % 4 == 1) y = x ^ 16'(1 << (i % N));
            apply(x, y, 1'(i % 2), (i % 2) ? "R2 random" : "R1 random");
        end
        for (int i = 0; i < 200; i++) begin
            logic [N-1:0] x;
            x = 16'($urandom);
            apply(x, x, 1'b1, "R3 random equal");
        end
    endtask

    // Non-power-of-two width: the worked example plus random vectors.
    task automatic t_width12;
        @(negedge clk);
        a12 = 12'b101100111100; b12 = 12'b100111101111; sub12 = 1'b1;
        #1;
        n_checks++;
        if (int'(cnt12) != 3) begin
            n_fail++;
            $display("FAIL R6 example: actual=%0d expected=3", cnt12);
        end
        for (int i = 0; i < 1000; i++) begin
            logic [M-1:0] r;
            @(negedge clk);
            a12 = 12'($urandom); b12 = 12'($urandom); sub12 = 1'(i % 2);
            #1;
            r = sub12 ? (a12 - b12) : (a12 + b12);
            n_checks++;
            if (int'(cnt12) != ref_lz({20'h0, r}, M)) begin
                n_fail++;
                $display("FAIL R6 width12: a=%h b=%h sub=%0d actual=%0d expected=%0d",
                         a12, b12, sub12, cnt12, ref_lz({20'h0, r}, M));
            end
        end
    endtask

    // Count settles from inputs alone, with no clock edge in between.
    task automatic t_no_clock;
        @(posedge clk);
        #1;
        a = 16'h0040; b = 16'h0000; sub = 1'b0;
        #0.5;
        chk("R7 settles without clock", int'(cnt), 9);
        a = 16'h0003; b = 16'h0001; sub = 1'b1;
        #0.5;
        chk("R7 settles without clock", int'(cnt), 14);
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0;
        a12 = '0; b12 = '0; sub12 = 1'b0;
        fork
            begin
                repeat (3) @(posedge clk);
                t_reset();
                t_add_directed();
                t_sub_directed();
                t_zero_results();
                t_random();
                t_width12();
                t_no_clock();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=done");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule